// File: doc/BRIEF.md
# PTP Transmit Frame Slot Scheduler

This block sends timing-protocol messages that software has already composed inside a slotted byte buffer. The buffer holds eight slots of 256 bytes each; slots 0 to 5 are reserved for Sync, Follow_Up, Pdelay_Req, Pdelay_Resp, Pdelay_Resp_Follow_Up and Announce, and slots 6 and 7 are free for other use. Software fills a slot through a byte-wide write port, then asks for it to be sent by writing a 1 to that slot's request bit in a 32-bit control register.

Each request raises a waiting flag for its slot. The scheduler takes one waiting slot at a time, lowest index first, and streams its bytes to the MAC over a valid/ready byte interface that marks the first and last byte of each frame. Once the final byte is taken, the slot's flag drops and the control register reports that slot as the last one sent. Software polls the eight waiting flags together to see whether any transmission is still outstanding.

Top module: `ptp_tx_slot_sched`

## Requirements
- R1: While reset is asserted and right after it, the control register reads zero and `tx_valid_o` is low.
- R2: A control write with bit i (bits 7:0) set raises waiting flag i, visible in read bit 8+i from the cycle after the write; request bits 7:0 always read as zero.
- R3: When several slots are waiting, the lowest-numbered one is sent first.
- R4: A frame that has started is always sent to its end before any other slot, even if a lower-numbered slot becomes waiting meanwhile.
- R5: Slot k occupies buffer bytes k*256 to k*256+255. Bytes 0 (high) and 1 (low) of a slot hold a 16-bit frame length L; the frame is the L bytes starting at slot byte 2. The first byte carries `tx_sof_o`, the last carries `tx_eof_o` (both on a one-byte frame).
- R6: In the cycle the last byte is accepted, the slot's waiting flag clears and read bits 18:16 take the slot index; both are visible from the next cycle.
- R7: A slot whose length is 0 or above 254 sends no bytes; its waiting flag still clears and the last-sent index is left unchanged.
- R8: A request for a slot that is already waiting has no further effect: the frame goes out once.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, data, start and end markers hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data; bits 7:0 are send requests |
| ctrl_rdata_o | output | 32 | Control read: 15:8 waiting flags, 18:16 last-sent index |
| mem_we_i | input | 1 | Slot buffer byte write strobe |
| mem_addr_i | input | 11 | Slot buffer byte address (slot*256 + offset) |
| mem_wdata_i | input | 8 | Slot buffer write byte |
| tx_valid_o | output | 1 | Byte valid towards the MAC |
| tx_ready_i | input | 1 | MAC accepts the byte |
| tx_data_o | output | 8 | Frame byte |
| tx_sof_o | output | 1 | First byte of frame |
| tx_eof_o | output | 1 | Last byte of frame |

## Verification
A wrong waiting mask shows up at the ports either as a frame sent twice, a frame never sent, or a stale bit in the control read, visible one cycle after the write or after the final byte. A wrong choice of slot or a lost frame boundary shows at the first byte of the next frame as an out-of-order payload or a misplaced start or end marker. A bad length decode either truncates the byte stream, runs past the expected end marker, or emits bytes for a slot that should have been dropped within two cycles of its request.

// File: rtl/ptp_tx_pkg.sv
package ptp_tx_pkg;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned HDR_BYTES = 2;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } stream_state_e;
endpackage

// File: rtl/ptp_slot_mem.sv
module ptp_slot_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned NRD    = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [7:0]                 wdata_i,
  input  logic [NRD-1:0][ADDR_W-1:0] raddr_i,
  output logic [NRD-1:0][7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/ptp_pend_arb.sv
module ptp_pend_arb #(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] set_i,
  input  logic                 clr_i,
  input  logic [IDX_W-1:0]     clr_idx_i,
  input  logic                 sent_i,
  output logic [NUM_SLOTS-1:0] pend_o,
  output logic                 any_o,
  output logic [IDX_W-1:0]     pick_o,
  output logic [IDX_W-1:0]     last_o
);
  logic [NUM_SLOTS-1:0] pend_q, clr_mask;
  logic [IDX_W-1:0]     last_q;

  assign clr_mask = clr_i ? (NUM_SLOTS'(1) << clr_idx_i) : '0;

  // clear wins over a repeated request for a slot already waiting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      last_q <= '0;
    end else begin
      pend_q <= (pend_q | set_i) & ~clr_mask;
      if (sent_i) last_q <= clr_idx_i;
    end
  end

  // fixed priority, lowest index wins
  always_comb begin
    pick_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pend_q[i]) pick_o = IDX_W'(i);
    end
  end

  assign any_o  = |pend_q;
  assign pend_o = pend_q;
  assign last_o = last_q;
endmodule

// File: rtl/ptp_tx_stream.sv
module ptp_tx_stream
  import ptp_tx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 8,
  parameter int unsigned SLOT_BYTES = 256,
  localparam int unsigned IDX_W   = $clog2(NUM_SLOTS),
  localparam int unsigned OFF_W   = $clog2(SLOT_BYTES),
  localparam int unsigned ADDR_W  = IDX_W + OFF_W,
  localparam int unsigned MAX_LEN = SLOT_BYTES - HDR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  pick_i,
  input  logic [7:0]        len_hi_i,
  input  logic [7:0]        len_lo_i,
  input  logic [7:0]        dat_i,
  output logic [ADDR_W-1:0] dat_addr_o,
  output logic              clr_o,
  output logic [IDX_W-1:0]  clr_idx_o,
  output logic              sent_o,
  output logic [IDX_W-1:0]  cur_slot_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o
);
  stream_state_e    state_q;
  logic [IDX_W-1:0] cur_q;
  logic [OFF_W-1:0] len_q, cnt_q;
  logic [LEN_W-1:0] len_w;
  logic             len_ok, last_beat, sending, beat_done, drop;

  assign len_w     = {len_hi_i, len_lo_i};
  assign len_ok    = (len_w != '0) && (len_w <= LEN_W'(MAX_LEN));
  assign sending   = (state_q == ST_SEND);
  assign last_beat = (cnt_q == len_q - OFF_W'(1));
  assign beat_done = sending && tx_ready_i && last_beat;
  assign drop      = !sending && any_i && !len_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (any_i && len_ok) begin
            state_q <= ST_SEND;
            cur_q   <= pick_i;
            len_q   <= len_w[OFF_W-1:0];
            cnt_q   <= '0;
          end
        end
        ST_SEND: begin
          if (tx_ready_i) begin
            if (last_beat) state_q <= ST_IDLE;
            else           cnt_q   <= cnt_q + OFF_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dat_addr_o = {cur_q, cnt_q + OFF_W'(HDR_BYTES)};
  assign tx_valid_o = sending;
  assign tx_data_o  = dat_i;
  assign tx_sof_o   = sending && (cnt_q == '0);
  assign tx_eof_o   = sending && last_beat;
  assign clr_o      = drop || beat_done;
  assign sent_o     = beat_done;
  assign clr_idx_o  = sending ? cur_q : pick_i;
  assign cur_slot_o = cur_q;
endmodule

// File: rtl/ptp_tx_slot_sched.sv
module ptp_tx_slot_sched #(
  parameter int unsigned NUM_SLOTS  = 8,
  parameter int unsigned SLOT_BYTES = 256,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned OFF_W    = $clog2(SLOT_BYTES),
  localparam int unsigned ADDR_W   = IDX_W + OFF_W,
  localparam int unsigned LAST_LSB = 2 * NUM_SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic [31:0]       ctrl_rdata_o,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [7:0]        mem_wdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o
);
  logic [NUM_SLOTS-1:0]   set_req, pend;
  logic                   any_pend, clr, sent;
  logic [IDX_W-1:0]       pick, clr_idx, last_idx, cur_slot;
  logic [ADDR_W-1:0]      dat_addr;
  logic [2:0][ADDR_W-1:0] rd_addr;
  logic [2:0][7:0]        rd_data;
  logic                   unused_wdata;

  assign set_req      = ctrl_we_i ? ctrl_wdata_i[NUM_SLOTS-1:0] : '0;
  assign unused_wdata = ^ctrl_wdata_i[31:NUM_SLOTS];

  assign rd_addr[0] = {pick, OFF_W'(0)};
  assign rd_addr[1] = {pick, OFF_W'(1)};
  assign rd_addr[2] = dat_addr;

  ptp_slot_mem #(.ADDR_W(ADDR_W), .NRD(3)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we_i),
    .waddr_i (mem_addr_i),
    .wdata_i (mem_wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  ptp_pend_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_req),
    .clr_i     (clr),
    .clr_idx_i (clr_idx),
    .sent_i    (sent),
    .pend_o    (pend),
    .any_o     (any_pend),
    .pick_o    (pick),
    .last_o    (last_idx)
  );

  ptp_tx_stream #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_stream (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (any_pend),
    .pick_i     (pick),
    .len_hi_i   (rd_data[0]),
    .len_lo_i   (rd_data[1]),
    .dat_i      (rd_data[2]),
    .dat_addr_o (dat_addr),
    .clr_o      (clr),
    .clr_idx_o  (clr_idx),
    .sent_o     (sent),
    .cur_slot_o (cur_slot),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .tx_sof_o   (tx_sof_o),
    .tx_eof_o   (tx_eof_o)
  );

  // request bits are write-only and read as zero
  always_comb begin
    ctrl_rdata_o = '0;
    ctrl_rdata_o[2*NUM_SLOTS-1:NUM_SLOTS] = pend;
    ctrl_rdata_o[LAST_LSB +: IDX_W]       = last_idx;
  end
endmodule

// File: rtl/ptp_tx_sched_chk.sv
module ptp_tx_sched_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned LAST_LSB = 2 * NUM_SLOTS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [31:0]      ctrl_wdata_i,
  input logic [31:0]      ctrl_rdata_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic [7:0]       tx_data_o,
  input logic             tx_sof_o,
  input logic             tx_eof_o,
  input logic [IDX_W-1:0] cur_slot_i
);
  logic [NUM_SLOTS-1:0] pend, new_req;
  logic [IDX_W-1:0]     last_idx;

  assign pend     = ctrl_rdata_o[2*NUM_SLOTS-1:NUM_SLOTS];
  assign last_idx = ctrl_rdata_o[LAST_LSB +: IDX_W];
  assign new_req  = ctrl_wdata_i[NUM_SLOTS-1:0] & ~pend;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!tx_valid_o && ctrl_rdata_o == '0);
    end
  end

  p_req_sets_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ((pend & $past(new_req)) == $past(new_req)));

  p_valid_needs_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> pend[cur_slot_i]);

  p_frame_starts_sof_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> tx_sof_o);

  p_last_on_eof_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && tx_eof_o) |=>
      (last_idx == $past(cur_slot_i)) && !pend[$past(cur_slot_i)]);

  p_hold_on_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_sof_o) && $stable(tx_eof_o)));
endmodule

bind ptp_tx_slot_sched ptp_tx_sched_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .tx_valid_o   (tx_valid_o),
  .tx_ready_i   (tx_ready_i),
  .tx_data_o    (tx_data_o),
  .tx_sof_o     (tx_sof_o),
  .tx_eof_o     (tx_eof_o),
  .cur_slot_i   (cur_slot)
);

// File: tb/ptp_tx_slot_sched_tb_top.sv
`timescale 1ns/1ps
module ptp_tx_slot_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        mem_we = 1'b0;
  logic [10:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic        tx_valid, tx_ready, tx_sof, tx_eof;
  logic [7:0]  tx_data;

  int checks = 0;
  int failures = 0;
  int ready_mode = 0;
  int cyc = 0;
  bit finished = 0;
  logic [9:0] exp_q [$];

  always #2 clk = ~clk;

  ptp_tx_slot_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_sof_o(tx_sof), .tx_eof_o(tx_eof)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ready pattern
  initial begin
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 2) ? (cyc % 3 != 0) : 1'b0;
    end
  end

  // monitor: pop and compare every accepted byte
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R7 unexpected byte", {22'd0, tx_sof, tx_eof, tx_data}, 32'h0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({tx_sof, tx_eof, tx_data} == e, "R5 byte/markers", {22'd0, tx_sof, tx_eof, tx_data}, {22'd0, e});
        end
      end
    end
  end

  task automatic wr_byte(input int addr, input logic [7:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_addr = 11'(addr); mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic load_slot(input int slot, input int len, input logic [7:0] seed);
    wr_byte(slot * 256, 8'(len >> 8));
    wr_byte(slot * 256 + 1, 8'(len));
    for (int j = 0; j < len && j < 254; j++) wr_byte(slot * 256 + 2 + j, seed + 8'(j));
  endtask

  // driver side of the scoreboard
  task automatic push_frame(input int len, input logic [7:0] seed);
    for (int j = 0; j < len; j++)
      exp_q.push_back({(j == 0), (j == len - 1), seed + 8'(j)});
  endtask

  task automatic send(input logic [7:0] mask);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = {24'd0, mask};
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
    #1;
  endtask

  task automatic wait_idle(input string tag);
    bit done = 0;
    for (int k = 0; k < 3000 && !done; k++) begin
      @(negedge clk); #1;
      if (exp_q.size() == 0 && ctrl_rdata[15:8] == 8'h00 && !tx_valid) done = 1;
    end
    chk(done, tag, {24'd0, ctrl_rdata[15:8]}, 32'h0);
  endtask

  task automatic idle_watch(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (tx_valid) seen = 1;
    end
    chk(!seen, tag, {31'd0, seen}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d0;
    repeat (3) @(negedge clk);
    #1;
    chk(ctrl_rdata == 32'h0, "R1 ctrl during reset", ctrl_rdata, 32'h0);
    chk(!tx_valid, "R1 valid during reset", {31'd0, tx_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ctrl_rdata == 32'h0 && !tx_valid, "R1 after reset", ctrl_rdata, 32'h0);

    load_slot(0, 4, 8'h10);
    load_slot(1, 3, 8'h20);
    load_slot(2, 1, 8'h30);
    load_slot(3, 6, 8'h40);
    load_slot(4, 0, 8'h00);
    load_slot(5, 5, 8'h50);
    load_slot(6, 20, 8'h60);
    load_slot(7, 254, 8'h70);

    // R2 / R9: single request with MAC stalled
    ready_mode = 0;
    push_frame(4, 8'h10);
    send(8'h01);
    chk(ctrl_rdata[15:8] == 8'h01, "R2 waiting flag set", {24'd0, ctrl_rdata[15:8]}, 32'h01);
    chk(ctrl_rdata[7:0] == 8'h00, "R2 send bits read zero", {24'd0, ctrl_rdata[7:0]}, 32'h0);
    repeat (2) @(negedge clk); #1;
    d0 = tx_data;
    chk(tx_valid && tx_sof && d0 == 8'h10, "R5 first byte presented", {22'd0, tx_sof, tx_valid, d0}, 32'h310);
    repeat (3) @(negedge clk); #1;
    chk(tx_valid && tx_sof && !tx_eof && tx_data == d0, "R9 held on stall", {22'd0, tx_sof, tx_eof, tx_data}, {22'd0, 2'b10, d0});
    ready_mode = 1;
    wait_idle("R6 slot 0 drained");
    chk(ctrl_rdata[18:16] == 3'd0, "R6 last index 0", {29'd0, ctrl_rdata[18:16]}, 32'd0);

    // R3: three at once, lowest first; includes one-byte and maximum-length frames
    ready_mode = 2;
    push_frame(1, 8'h30);
    push_frame(5, 8'h50);
    push_frame(254, 8'h70);
    send(8'hA4);
    chk(ctrl_rdata[15:8] == 8'hA4, "R2 three flags", {24'd0, ctrl_rdata[15:8]}, 32'hA4);
    wait_idle("R3 all three drained");
    chk(ctrl_rdata[18:16] == 3'd7, "R6 last index 7", {29'd0, ctrl_rdata[18:16]}, 32'd7);

    // R4: lower slot requested mid-frame waits
    ready_mode = 1;
    push_frame(20, 8'h60);
    send(8'h40);
    for (int k = 0; k < 20 && !tx_valid; k++) begin @(negedge clk); #1; end
    push_frame(3, 8'h20);
    send(8'h02);
    chk(ctrl_rdata[15:8] == 8'h42, "R4 both waiting", {24'd0, ctrl_rdata[15:8]}, 32'h42);
    wait_idle("R4 frames drained in order");
    chk(ctrl_rdata[18:16] == 3'd1, "R6 last index 1", {29'd0, ctrl_rdata[18:16]}, 32'd1);

    // R8: repeated request while waiting
    ready_mode = 0;
    push_frame(6, 8'h40);
    send(8'h08);
    repeat (3) @(negedge clk);
    send(8'h08);
    chk(ctrl_rdata[15:8] == 8'h08, "R8 flag unchanged", {24'd0, ctrl_rdata[15:8]}, 32'h08);
    ready_mode = 1;
    wait_idle("R8 frame drained");
    idle_watch(20, "R8 no second copy");
    chk(ctrl_rdata[18:16] == 3'd3, "R6 last index 3", {29'd0, ctrl_rdata[18:16]}, 32'd3);

    // R7: zero length
    send(8'h10);
    chk(ctrl_rdata[15:8] == 8'h10, "R7 flag set for zero length", {24'd0, ctrl_rdata[15:8]}, 32'h10);
    idle_watch(4, "R7 zero length sends nothing");
    chk(ctrl_rdata[15:8] == 8'h00, "R7 zero length flag cleared", {24'd0, ctrl_rdata[15:8]}, 32'h0);
    chk(ctrl_rdata[18:16] == 3'd3, "R7 last index kept", {29'd0, ctrl_rdata[18:16]}, 32'd3);

    // R7: length 255 and 256
    wr_byte(4 * 256 + 1, 8'hFF);
    send(8'h10);
    idle_watch(4, "R7 length 255 sends nothing");
    chk(ctrl_rdata[15:8] == 8'h00 && ctrl_rdata[18:16] == 3'd3, "R7 length 255 dropped", ctrl_rdata, 32'h30000);
    wr_byte(4 * 256, 8'h01);
    wr_byte(4 * 256 + 1, 8'h00);
    send(8'h10);
    idle_watch(4, "R7 length 256 sends nothing");
    chk(ctrl_rdata[15:8] == 8'h00 && ctrl_rdata[18:16] == 3'd3, "R7 length 256 dropped", ctrl_rdata, 32'h30000);

    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 32'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule